// File: doc/BRIEF.md
# Presettable Two-Section Ripple Counter

This block is a 4-bit counter built from two sections with separate clocks. Each section advances on the falling edge of its own clock. The low section is one flip-flop that toggles on every falling edge of `lo_clk`. The high section is three flip-flops clocked by `hi_clk`. With `DECADE = 1` the high section divides by five: it walks the states QS_ZERO, QS_ONE, QS_TWO, QS_THREE and QS_FOUR, then wraps from QS_FOUR back to QS_ZERO. The state is coded on `cnt[3:1]` with `cnt[1]` as the least significant bit. The three codes 5, 6 and 7 are the recovery states QS_BAD5, QS_BAD6 and QS_BAD7, and each of them moves to QS_ZERO on the next high-section edge. With `DECADE = 0` the high section is a plain divide-by-eight binary counter.

The user joins the two sections outside the block:
- Feeding `cnt[0]` into `hi_clk` and clocking `lo_clk` gives an 8-4-2-1 decimal count from 0 to 9.
- In the decade build, feeding `cnt[3]` into `lo_clk` and clocking `hi_clk` gives bi-quinary counting. `cnt[0]` is then a square wave with equal high and low times, at one tenth of the input rate.
- In the binary build, feeding `cnt[0]` into `hi_clk` gives a modulo-16 up counter.

Two asynchronous active-low controls sit above counting. `rst_n` clears all four bits and beats everything else. `load_n` copies `din` into the flip-flops while it is low. Held low, `load_n` makes the block a transparent 4-bit latch. When it is released, the loaded value is held, and counting resumes from it on the next falling clock edge.

Top module: `ripple_div_counter`

## Requirements
- R1: While `rst_n` is low, `cnt` is 0 regardless of `load_n`, `din` and both clocks.
- R2: While `rst_n` is high and `load_n` is low, `cnt` follows `din` without any clock edge.
- R3: After `load_n` rises, `cnt` keeps the loaded value when `din` changes, and counting resumes from it on the next falling clock edge.
- R4: `cnt[0]` inverts on each falling edge of `lo_clk`; rising edges leave it unchanged.
- R5: In the decade build, each falling edge of `hi_clk` moves `cnt[3:1]` from state k to k+1 for k = 0 to 3, and from 4 to 0.
- R6: With `cnt[0]` wired to `hi_clk` in the decade build, falling edges of `lo_clk` step `cnt` through 0 to 9 and then back to 0.
- R7: With `cnt[3]` wired to `lo_clk` in the decade build, falling edges of `hi_clk` give `cnt` values 2,4,6,8,1,3,5,7,9,0 from 0, and `cnt[0]` is high for exactly 5 of every 10 edges.
- R8: In the decade build, a loaded `cnt[3:1]` value of 5, 6 or 7 becomes 0 on the next falling edge of `hi_clk`, and `cnt[0]` is kept.
- R9: In the binary build with `cnt[0]` wired to `hi_clk`, each falling edge of `lo_clk` adds 1 to `cnt` modulo 16.
- R10: Falling clock edges while `load_n` is low leave `cnt` equal to `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lo_clk | input | 1 | Falling-edge clock of the divide-by-two section |
| hi_clk | input | 1 | Falling-edge clock of the divide-by-five (or divide-by-eight) section |
| rst_n | input | 1 | Asynchronous clear, active low, highest priority |
| load_n | input | 1 | Asynchronous parallel load, active low |
| din | input | 4 | Parallel data copied while `load_n` is low |
| cnt | output | 4 | Counter state; bit 0 is the low section |

## Verification
Asynchronous load and clocked counting can meet in the same cycle. The bench holds `load_n` low and gives both section clocks falling edges. It judges the result by checking that `cnt` still equals `din`, then that the first edge after release counts on from that value. Clear and load also overlap: clear is held while a load of all ones is requested, and the bench expects zero. It then expects the data to appear the moment clear lets go.

// File: rtl/ripple_cnt_pkg.sv
package ripple_cnt_pkg;
    localparam int LO_W   = 1;
    localparam int HI_W   = 3;
    localparam int DATA_W = LO_W + HI_W;

    typedef enum logic [HI_W-1:0] {
        QS_ZERO  = 3'd0,
        QS_ONE   = 3'd1,
        QS_TWO   = 3'd2,
        QS_THREE = 3'd3,
        QS_FOUR  = 3'd4,
        QS_BAD5  = 3'd5,
        QS_BAD6  = 3'd6,
        QS_BAD7  = 3'd7
    } quin_e;
endpackage

// File: rtl/ripple_cnt_flop.sv
module ripple_cnt_flop (
    input  logic fclk,
    input  logic rst_n,
    input  logic load_n,
    input  logic din,
    input  logic nxt,
    output logic q
);
    logic clr_n;
    logic set_n;

    always_comb begin
        clr_n = rst_n & (load_n | din);
        set_n = ~(rst_n & ~load_n & din);
    end

    always_ff @(negedge fclk or negedge clr_n or negedge set_n) begin
        if (!clr_n)
            q <= 1'b0;
        else if (!set_n)
            q <= 1'b1;
        else
            q <= nxt;
    end

    // R1
    reset_clears_chk: assert property (@(negedge fclk) (!rst_n) |-> (q == 1'b0));

    // R10
    load_overrides_chk: assert property (@(negedge fclk) disable iff (!rst_n)
        (!load_n) |-> (q == din));
endmodule

// File: rtl/ripple_cnt_lo.sv
module ripple_cnt_lo
    import ripple_cnt_pkg::*;
(
    input  logic            fclk,
    input  logic            rst_n,
    input  logic            load_n,
    input  logic [LO_W-1:0] din,
    output logic [LO_W-1:0] q
);
    logic [LO_W-1:0] nxt;

    always_comb nxt = ~q;

    genvar gi;
    generate
        for (gi = 0; gi < LO_W; gi++) begin : g_bit
            ripple_cnt_flop u_flop (
                .fclk   (fclk),
                .rst_n  (rst_n),
                .load_n (load_n),
                .din    (din[gi]),
                .nxt    (nxt[gi]),
                .q      (q[gi])
            );
        end
    endgenerate
endmodule

// File: rtl/ripple_cnt_hi.sv
module ripple_cnt_hi
    import ripple_cnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic            fclk,
    input  logic            rst_n,
    input  logic            load_n,
    input  logic [HI_W-1:0] din,
    output logic [HI_W-1:0] q
);
    logic [HI_W-1:0] nxt;

    generate
        if (DECADE) begin : g_quin
            quin_e state;
            quin_e nxt_s;

            always_comb state = quin_e'(q);

            always_comb begin
                unique case (state)
                    QS_ZERO:  nxt_s = QS_ONE;
                    QS_ONE:   nxt_s = QS_TWO;
                    QS_TWO:   nxt_s = QS_THREE;
                    QS_THREE: nxt_s = QS_FOUR;
                    QS_FOUR:  nxt_s = QS_ZERO;
                    QS_BAD5:  nxt_s = QS_ZERO;
                    QS_BAD6:  nxt_s = QS_ZERO;
                    QS_BAD7:  nxt_s = QS_ZERO;
                endcase
            end

            always_comb nxt = nxt_s;

            // R8
            illegal_recover_chk: assert property (@(negedge fclk) disable iff (!rst_n)
                (state > QS_FOUR) |-> (nxt_s == QS_ZERO));

            // R5
            legal_closed_chk: assert property (@(negedge fclk) disable iff (!rst_n)
                (state <= QS_FOUR) |-> ((nxt_s <= QS_FOUR) && (nxt_s != state)));
        end else begin : g_oct
            always_comb nxt = q + 1'b1;
        end
    endgenerate

    genvar gi;
    generate
        for (gi = 0; gi < HI_W; gi++) begin : g_bit
            ripple_cnt_flop u_flop (
                .fclk   (fclk),
                .rst_n  (rst_n),
                .load_n (load_n),
                .din    (din[gi]),
                .nxt    (nxt[gi]),
                .q      (q[gi])
            );
        end
    endgenerate
endmodule

// File: rtl/ripple_div_counter.sv
module ripple_div_counter
    import ripple_cnt_pkg::*;
#(
    parameter bit DECADE = 1'b1
) (
    input  logic              lo_clk,
    input  logic              hi_clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] cnt
);
    logic [LO_W-1:0] lo_q;
    logic [HI_W-1:0] hi_q;

    ripple_cnt_lo u_lo (
        .fclk   (lo_clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .din    (din[LO_W-1:0]),
        .q      (lo_q)
    );

    ripple_cnt_hi #(.DECADE(DECADE)) u_hi (
        .fclk   (hi_clk),
        .rst_n  (rst_n),
        .load_n (load_n),
        .din    (din[DATA_W-1:LO_W]),
        .q      (hi_q)
    );

    always_comb cnt = {hi_q, lo_q};
endmodule

// File: tb/test_ripple_div_counter.sv
module test_ripple_div_counter;
    localparam int MODE_BCD = 0;
    localparam int MODE_BIQ = 1;
    localparam int MODE_MAN = 2;
    localparam int NVEC = 24;

    // bit5: reset first, bit4: 0 = decimal wiring, 1 = bi-quinary wiring, [3:0]: expected cnt
    localparam logic [5:0] VEC [NVEC] = '{
        6'h21, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h08,
        6'h09, 6'h00, 6'h01, 6'h02,
        6'h32, 6'h14, 6'h16, 6'h18, 6'h11, 6'h13, 6'h15, 6'h17,
        6'h19, 6'h10, 6'h12, 6'h14
    };

    logic       clk = 1'b1;
    logic       rst_n = 1'b0;
    logic       load_n = 1'b1;
    logic [3:0] din = 4'h0;
    logic       strobe = 1'b0;
    logic       bstrobe = 1'b0;
    logic       m0 = 1'b0;
    logic       m1 = 1'b0;
    int         mode = MODE_MAN;
    logic       lo_clk, hi_clk;
    logic [3:0] cnt, bcnt;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    assign lo_clk = (mode == MODE_BIQ) ? cnt[3] : (mode == MODE_MAN) ? m0 : strobe;
    assign hi_clk = (mode == MODE_BCD) ? cnt[0] : (mode == MODE_MAN) ? m1 : strobe;

    ripple_div_counter #(.DECADE(1'b1)) i_ripple_div_counter (
        .lo_clk (lo_clk), .hi_clk (hi_clk), .rst_n (rst_n),
        .load_n (load_n), .din (din), .cnt (cnt)
    );

    ripple_div_counter #(.DECADE(1'b0)) i_ripple_div_counter_bin (
        .lo_clk (bstrobe), .hi_clk (bcnt[0]), .rst_n (rst_n),
        .load_n (1'b1), .din (4'h0), .cnt (bcnt)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset(input int new_mode);
        rst_n = 1'b0;
        #2;
        mode = new_mode;
        m0 = 1'b0;
        m1 = 1'b0;
        strobe = 1'b0;
        #10;
        rst_n = 1'b1;
        #10;
    endtask

    task automatic strobe_fall();
        @(posedge clk);
        strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0;
        #2;
    endtask

    task automatic fall0();
        m0 = 1'b1; #4; m0 = 1'b0; #4;
    endtask

    task automatic fall1();
        m1 = 1'b1; #4; m1 = 1'b0; #4;
    endtask

    task automatic load_pulse(input logic [3:0] v);
        din = v; #2; load_n = 1'b0; #4; load_n = 1'b1; #4;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int ones;
        #20;
        // Table: decimal wiring (R6) and bi-quinary wiring (R7)
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][5]) do_reset(VEC[i][4] ? MODE_BIQ : MODE_BCD);
            strobe_fall();
            check(VEC[i][4] ? "R7 biquinary step" : "R6 decimal step", cnt, VEC[i][3:0]);
        end
        // R7: duty of cnt[0] over one full period of ten edges
        ones = 0;
        for (int i = 0; i < 10; i++) begin
            strobe_fall();
            if (cnt[0]) ones++;
        end
        check("R7 duty count", 4'(ones), 4'd5);

        // R1: clear state, then clear beats load
        rst_n = 1'b0;
        #2;
        mode = MODE_MAN;
        #6;
        check("R1 reset state", cnt, 4'h0);
        din = 4'hF;
        load_n = 1'b0;
        #6;
        check("R1 reset over load", cnt, 4'h0);
        fall0();
        fall1();
        check("R1 reset over clocks", cnt, 4'h0);
        // R2: transparent latch
        rst_n = 1'b1;
        #4;
        check("R2 load after reset release", cnt, 4'hF);
        din = 4'h5; #4;
        check("R2 follow data", cnt, 4'h5);
        din = 4'hA; #4;
        check("R2 follow data", cnt, 4'hA);
        // R3: hold after release
        load_n = 1'b1; #2;
        din = 4'h3; #4;
        check("R3 hold", cnt, 4'hA);
        // R8: recovery from codes 5, 6, 7
        fall1();
        check("R8 recover from 5", cnt, 4'h0);
        load_pulse(4'hE);
        check("R2 load 7", cnt, 4'hE);
        fall1();
        check("R8 recover from 7", cnt, 4'h0);
        load_pulse(4'hD);
        fall1();
        check("R8 recover from 6 keeps bit0", cnt, 4'h1);
        // R4: low section toggling
        m0 = 1'b1; #4;
        check("R4 rising edge ignored", cnt, 4'h1);
        m0 = 1'b0; #4;
        check("R4 toggle to 0", cnt, 4'h0);
        fall0();
        check("R4 toggle to 1", cnt, 4'h1);
        // R5: divide-by-five walk
        load_pulse(4'h0);
        fall1(); check("R5 state 1", cnt, 4'h2);
        fall1(); check("R5 state 2", cnt, 4'h4);
        fall1(); check("R5 state 3", cnt, 4'h6);
        fall1(); check("R5 state 4", cnt, 4'h8);
        fall1(); check("R5 wrap to 0", cnt, 4'h0);
        // R10: load overrides clock edges
        din = 4'h3; #2;
        load_n = 1'b0; #4;
        fall0();
        fall1();
        check("R10 edges during load", cnt, 4'h3);
        // R3: counting resumes after release
        load_n = 1'b1; #4;
        fall0();
        check("R3 resume low section", cnt, 4'h2);
        fall1();
        check("R3 resume high section", cnt, 4'h4);

        // R9: binary build, modulo 16
        do_reset(MODE_MAN);
        check("R9 binary reset", bcnt, 4'h0);
        begin
            logic [3:0] model;
            model = 4'h0;
            for (int i = 0; i < 20; i++) begin
                bstrobe = 1'b1; #4; bstrobe = 1'b0; #4;
                model = model + 4'h1;
                check("R9 binary count", bcnt, model);
            end
        end
        finish_run();
    end
endmodule